// File: doc/BRIEF.md
# Local processor bus target

This block is a synchronous slave port through which a local 32-bit processor reads and writes a small word-addressed register bank. Every bus signal is active low. An access opens when address strobe and chip select are both low at a rising edge. The block then captures the word address, the direction and the byte lane enables, and answers each data phase with a ready strobe. The processor paces the transfer by qualifying that strobe. Holding the wait input low stretches the current phase. Holding the burst-last input low ends the access after the current word.

The bank holds 16 words. Words 0 to 14 are plain storage. Word 15 is a status word: bit 0 is a sticky flag for a processor self-test failure, and bit 1 is a sticky flag for a pacing protocol error. A system that uses neither bursts nor waits ties wait high and burst-last low, and every access is then a single word.

Top module: `lpb_target`

## Requirements
- R1: After a synchronous reset, ready is high, both status flags are 0 and every storage word (0 to 14) reads as zero.
- R2: When address strobe and chip select are both low at a rising edge while idle, ready is low for the whole following clock cycle.
- R3: On a write, byte enable bit n low lets data bits 8n+7:8n into the addressed word; lanes whose enable is high keep their old value.
- R4: A read returns the full 32-bit word whatever the byte enables are, and the data is valid while ready is low.
- R5: An edge with ready low and wait low does not complete the phase: ready stays low, the address is held and no write takes effect.
- R6: An edge with ready low, wait low and burst-last low sets the error flag (status bit 1, also on port err_flag).
- R7: An edge with ready low, wait high and burst-last low completes the last word, and ready is high in the next cycle.
- R8: An edge with ready low, wait high and burst-last high completes a burst word, and the next phase uses the word address plus one, modulo 16.
- R9: A low level on fail_n at any rising edge sets the sticky failure flag (status bit 0, also on port fail_flag).
- R10: A completed write to word 15 with byte enable bit 0 low clears the failure flag if data bit 0 is 1 and the error flag if data bit 1 is 1. With byte enable bit 0 high it changes nothing. A flag set in the same cycle stays set.
- R11: With wait held high and burst-last held low, every access completes on its first ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Direction: low for write, high for read |
| addr | input | 4 | Starting word address |
| be_n | input | 4 | Byte lane enables, active low, write only |
| wdata | input | 32 | Write data |
| wait_n | input | 1 | Wait request, active low |
| last_n | input | 1 | Burst last word, active low |
| fail_n | input | 1 | Processor failure indication, active low |
| rdy_n | output | 1 | Data phase ready, active low |
| rdata | output | 32 | Read data, valid while rdy_n is low, zero otherwise |
| fail_flag | output | 1 | Sticky failure flag |
| err_flag | output | 1 | Sticky protocol error flag |

## Verification
Ready falls in the cycle right after the capturing edge. Read data is due in every cycle in which ready is low. A write, a flag set or a flag clear becomes visible in the cycle after the edge that completed it, so a written word is observed through the next access. The bench drives all inputs just after a falling edge and samples 1 ns later, in the same low clock half. Each expectation is therefore compared against the state that the preceding rising edge produced. Expected words come from a bench-side model of the bank that is updated only when a phase completes.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
    localparam int LPB_DW     = 32;
    localparam int LPB_AW     = 4;
    localparam int LPB_NB     = LPB_DW / 8;
    localparam int LPB_WORDS  = 2 ** LPB_AW;
    localparam int LPB_STAT   = LPB_WORDS - 1;
    localparam int LPB_NSTORE = LPB_WORDS - 1;

    typedef enum logic {ST_IDLE, ST_DATA} lpb_state_e;

    typedef struct packed {
        logic [LPB_AW-1:0] addr;
        logic              wr;
        logic [LPB_NB-1:0] lane;
    } lpb_xfer_t;

    function automatic logic [LPB_DW-1:0] lpb_merge(
        input logic [LPB_DW-1:0] old_w,
        input logic [LPB_DW-1:0] new_w,
        input logic [LPB_NB-1:0] lane);
        logic [LPB_DW-1:0] res;
        res = old_w;
        for (int b = 0; b < LPB_NB; b++) begin
            if (lane[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/lpb_seq.sv
module lpb_seq
    import lpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [LPB_AW-1:0] addr,
    input  logic [LPB_NB-1:0] be_n,
    input  logic              wait_n,
    input  logic              last_n,
    output logic              rdy_n,
    output lpb_xfer_t         cur,
    output logic              done,
    output logic              proto_err
);
    lpb_state_e state_q;
    lpb_xfer_t  cur_q;
    logic       in_data;

    always_comb begin
        in_data   = (state_q == ST_DATA);
        rdy_n     = ~in_data;
        done      = in_data & wait_n;
        proto_err = in_data & ~wait_n & ~last_n;
        cur       = cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!as_n && !cs_n) begin
                        cur_q.addr <= addr;
                        cur_q.wr   <= ~wr_n;
                        cur_q.lane <= ~be_n;
                        state_q    <= ST_DATA;
                    end
                end
                default: begin
                    if (wait_n) begin
                        if (!last_n) state_q <= ST_IDLE;
                        else cur_q.addr <= cur_q.addr + 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: ready follows the capturing edge
    p_ready_after_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (rdy_n && !as_n && !cs_n) |=> !rdy_n);

    // R5: a waited phase holds ready and address
    p_wait_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !wait_n) |=> (!rdy_n && $stable(cur_q.addr)));

    // R7: final word returns to idle
    p_last_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && wait_n && !last_n) |=> rdy_n);

    // R8: burst step advances the word address by one
    p_burst_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && wait_n && last_n) |=>
        (!rdy_n && cur_q.addr == $past(cur_q.addr) + 1'b1));
endmodule

// File: rtl/lpb_regbank.sv
module lpb_regbank
    import lpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lpb_xfer_t         cur,
    input  logic              done,
    input  logic              proto_err,
    input  logic              fail_n,
    input  logic [LPB_DW-1:0] wdata,
    output logic [LPB_DW-1:0] rd_word,
    output logic              fail_flag,
    output logic              err_flag
);
    logic [LPB_DW-1:0] store_q [LPB_NSTORE];
    logic              fail_q;
    logic              err_q;
    logic              wr_hit;
    logic              is_stat;
    logic              clr_hit;

    always_comb begin
        wr_hit  = done & cur.wr;
        is_stat = (cur.addr == LPB_AW'(LPB_STAT));
        clr_hit = wr_hit & is_stat & cur.lane[0];
        if (is_stat) rd_word = {{(LPB_DW-2){1'b0}}, err_q, fail_q};
        else         rd_word = store_q[cur.addr];
        fail_flag = fail_q;
        err_flag  = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < LPB_NSTORE; w++) store_q[w] <= '0;
        end else if (wr_hit && !is_stat) begin
            store_q[cur.addr] <= lpb_merge(store_q[cur.addr], wdata, cur.lane);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            fail_q <= ~fail_n    | (fail_q & ~(clr_hit & wdata[0]));
            err_q  <= proto_err  | (err_q  & ~(clr_hit & wdata[1]));
        end
    end

    // R6: protocol error is latched
    p_err_latched_r6: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> err_flag);

    // R10: without a clear the error flag never drops
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_hit) |=> err_flag);
endmodule

// File: rtl/lpb_target.sv
module lpb_target
    import lpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [LPB_AW-1:0] addr,
    input  logic [LPB_NB-1:0] be_n,
    input  logic [LPB_DW-1:0] wdata,
    input  logic              wait_n,
    input  logic              last_n,
    input  logic              fail_n,
    output logic              rdy_n,
    output logic [LPB_DW-1:0] rdata,
    output logic              fail_flag,
    output logic              err_flag
);
    lpb_xfer_t         cur;
    logic              done;
    logic              proto_err;
    logic [LPB_DW-1:0] rd_word;

    lpb_seq u_seq (
        .clk(clk), .rst(rst), .as_n(as_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .be_n(be_n), .wait_n(wait_n), .last_n(last_n),
        .rdy_n(rdy_n), .cur(cur), .done(done), .proto_err(proto_err)
    );

    lpb_regbank u_bank (
        .clk(clk), .rst(rst), .cur(cur), .done(done), .proto_err(proto_err),
        .fail_n(fail_n), .wdata(wdata), .rd_word(rd_word),
        .fail_flag(fail_flag), .err_flag(err_flag)
    );

    assign rdata = rdy_n ? '0 : rd_word;

    // R9: failure input is latched
    p_fail_latched_r9: assert property (@(posedge clk) disable iff (rst)
        !fail_n |=> fail_flag);
endmodule

// File: tb/lpb_target_tb_top.sv
`timescale 1ns/1ps
module lpb_target_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] wdata = '0;
    logic        wait_n = 1'b1, last_n = 1'b0, fail_n = 1'b1;
    logic        rdy_n;
    logic [31:0] rdata;
    logic        fail_flag, err_flag;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    logic [31:0] mem [15];
    bit mfail = 0;
    bit merr  = 0;

    always #2.5 clk = ~clk;

    lpb_target dut_i (
        .clk(clk), .rst(rst), .as_n(as_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .be_n(be_n), .wdata(wdata), .wait_n(wait_n),
        .last_n(last_n), .fail_n(fail_n), .rdy_n(rdy_n), .rdata(rdata),
        .fail_flag(fail_flag), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int a);
        if (a == 15) return {30'b0, merr, mfail};
        return mem[a];
    endfunction

    function automatic void m_write(input int a, input logic [31:0] d, input logic [3:0] ben);
        if (a == 15) begin
            if (!ben[0]) begin
                if (d[0]) mfail = 0;
                if (d[1]) merr = 0;
            end
        end else begin
            for (int b = 0; b < 4; b++)
                if (!ben[b]) mem[a][8*b +: 8] = d[8*b +: 8];
        end
    endfunction

    // One access: len words from start, waits wait cycles per word,
    // bad drives burst-last low during the waits.
    task automatic access(input bit wr, input int start, input int len,
                          input logic [3:0] ben, input int waits,
                          input logic [31:0] base, input bit bad);
        @(negedge clk);
        as_n = 0; cs_n = 0; addr = start[3:0]; wr_n = ~wr; be_n = ben;
        wait_n = 1; last_n = 1;
        @(negedge clk);
        as_n = 1; cs_n = 1; addr = 4'h0;
        #1 chk("R2 ready after capture", {31'b0, rdy_n}, 32'd0);
        for (int k = 0; k < len; k++) begin
            int a;
            logic [31:0] d;
            a = (start + k) % 16;
            d = base ^ (k * 32'h1111_1111);
            for (int w = 0; w < waits; w++) begin
                wait_n = 0; last_n = bad ? 1'b0 : 1'b1; wdata = 32'hBAD0_0000 | w;
                #1 chk("R5 held phase ready", {31'b0, rdy_n}, 32'd0);
                if (!wr) chk("R5 held phase data", rdata, m_read(a));
                @(negedge clk);
                if (bad) merr = 1;
            end
            wait_n = 1; last_n = (k == len - 1) ? 1'b0 : 1'b1; wdata = d;
            #1 chk("R8 phase ready", {31'b0, rdy_n}, 32'd0);
            if (!wr) chk("R4 R8 read word", rdata, m_read(a));
            @(negedge clk);
            if (wr) m_write(a, d, ben);
        end
        last_n = 0; wait_n = 1;
        #1 chk("R7 idle after last", {31'b0, rdy_n}, 32'd1);
        chk("R7 idle read data zero", rdata, 32'd0);
        chk("R6 err flag", {31'b0, err_flag}, {31'b0, merr});
        chk("R9 fail flag", {31'b0, fail_flag}, {31'b0, mfail});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 15; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1 chk("R1 reset ready", {31'b0, rdy_n}, 32'd1);
        chk("R1 reset flags", {30'b0, err_flag, fail_flag}, 32'd0);
        // R1 R4: read whole bank with lanes disabled
        access(0, 0, 16, 4'hF, 0, 0, 0);
        // R11: single-word writes
        for (int a = 0; a < 15; a++) access(1, a, 1, 4'h0, 0, 32'h1000_0001 * (a + 1), 0);
        access(0, 0, 16, 4'hA, 0, 0, 0);
        // R3: every lane combination on word 3
        for (int be = 0; be < 16; be++) begin
            access(1, 3, 1, be[3:0], 0, 32'hA5C3_0F00 ^ (be * 32'h0101_0101), 0);
            access(0, 3, 1, 4'b0101, 0, 0, 0);
        end
        // R5 R8: bursts with waits, wrapping through the status word
        access(1, 13, 5, 4'h0, 2, 32'h7E57_0001, 0);
        access(0, 14, 4, 4'hF, 1, 0, 0);
        access(1, 10, 8, 4'h6, 0, 32'h3C3C_5A5A, 0);
        access(0, 0, 16, 4'h0, 3, 0, 0);
        // R6: wait with burst-last low
        access(0, 1, 1, 4'hF, 1, 0, 1);
        chk("R6 error set", {31'b0, err_flag}, 32'd1);
        // R9: failure pulse
        @(negedge clk); fail_n = 0;
        @(negedge clk); fail_n = 1; mfail = 1;
        #1 chk("R9 fail set", {31'b0, fail_flag}, 32'd1);
        access(0, 15, 1, 4'hF, 0, 0, 0);
        // R10: lane 0 disabled leaves flags
        access(1, 15, 1, 4'b0001, 0, 32'h3, 0);
        chk("R10 no clear without lane 0", {30'b0, err_flag, fail_flag}, 32'd3);
        access(1, 15, 1, 4'b1110, 0, 32'h2, 0);
        chk("R10 clear error only", {30'b0, err_flag, fail_flag}, 32'd1);
        access(1, 15, 1, 4'b1110, 0, 32'h1, 0);
        chk("R10 clear failure", {30'b0, err_flag, fail_flag}, 32'd0);
        access(0, 0, 16, 4'h3, 0, 0, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule